// File: doc/BRIEF.md
# Token Permission Tracker

This block keeps a per-block token count for one node of a token-counting coherence scheme. The system owns a fixed number of tokens per memory block, and those tokens sit in caches, in the memory node or in transit. A node may read a block while it holds at least one of that block's tokens. It may write the block only while it holds every token.

The tracker takes two kinds of traffic, and both can occur in the same cycle:
- An arrival delivers a number of tokens for one block, with a flag that says whether data came with them.
- A send removes tokens from one block. Its evict form gives up the whole holding without any handshake. It also drops the block's data-valid flag.

The tracker reports the amount actually sent in the same cycle, so a wrapper can hand that amount to the interconnect. An update that would take a count below zero or above the system total is refused and flagged. The same module can stand for a memory node by starting with every token and with valid data.

Top module: `tok_tracker`

## Requirements
- R1: After synchronous reset a cache node (HOME_NODE=0) holds 0 tokens with data_valid low for every block. A home node (HOME_NODE=1) holds TOTAL_TOKENS with data_valid high for every block. tok_err is low after reset.
- R2: rd_ok[i] is high exactly when the count of block i is 1 or more.
- R3: wr_ok[i] is high exactly when the count of block i equals TOTAL_TOKENS.
- R4: An arrival (arr_valid, block arr_idx, amount arr_count) adds arr_count to that block's count at the next clock edge. An arrival with arr_data=1 sets the block's data_valid.
- R5: A send (snd_valid, snd_all=0) removes snd_count from block snd_idx at the next edge. The amount removed appears on sent_count in the same cycle.
- R6: A send with snd_all=1 is an eviction. It ignores snd_count and puts the whole held count on sent_count. At the next edge it leaves the count at 0 and clears data_valid.
- R7: An arrival and a send to the same block in one cycle set the count to the old count plus the received amount minus the sent amount.
- R8: An update whose result would be below 0 or above TOTAL_TOKENS leaves the count and data_valid unchanged. It drives sent_count to 0 and raises tok_err for the following cycle.
- R9: A block holding 0 tokens reports neither read nor write permission, even while its data_valid is still high.
- R10: Traffic for one block leaves the counts of all other blocks unchanged.
- R11: Several trackers that exchange only the amounts reported on sent_count conserve TOTAL_TOKENS per block. The total counts tokens in every tracker plus tokens in transit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | 1 | Token arrival present this cycle |
| arr_idx | input | IDX_W | Block index of the arrival |
| arr_count | input | CNT_W | Number of tokens arriving |
| arr_data | input | 1 | Arrival carries the block's data |
| snd_valid | input | 1 | Token send command present this cycle |
| snd_idx | input | IDX_W | Block index of the send |
| snd_count | input | CNT_W | Tokens to send (ignored on eviction) |
| snd_all | input | 1 | Eviction: send every held token |
| rd_ok | output | NUM_BLOCKS | Per-block read permission |
| wr_ok | output | NUM_BLOCKS | Per-block write permission |
| data_valid | output | NUM_BLOCKS | Per-block data-valid flag |
| tok_cnt | output | NUM_BLOCKS*CNT_W | Packed per-block token counts, block i at bits [i*CNT_W +: CNT_W] |
| sent_count | output | CNT_W | Tokens actually leaving this cycle |
| tok_err | output | 1 | Registered flag: the previous cycle's update was refused |

## Verification
Arrival and send can both target the same block in one cycle, and that overlap is the hard case. The bench first empties the block with an eviction. It then loads every starting count and applies every pairing of received and sent amounts as one combined cycle. Each outcome is judged against plain arithmetic: the merged sum when it lies in range, and otherwise an unchanged count with a raised error. A second setup passes tokens between a cache tracker and a home tracker through a one-cycle transit register, and the per-block sum is checked on every cycle.

// File: rtl/tok_pkg.sv
`timescale 1ns/1ps
package tok_pkg;

    typedef enum logic [1:0] {
        UPD_IDLE,
        UPD_OK,
        UPD_UNDER,
        UPD_OVER
    } upd_e;

    typedef struct packed {
        logic arr_hit;
        logic arr_data;
        logic snd_hit;
        logic snd_all;
    } slot_ctl_t;

    function automatic int cnt_width(input int total);
        return (total < 1) ? 1 : $clog2(total + 1);
    endfunction

    function automatic int idx_width(input int blocks);
        return (blocks < 2) ? 1 : $clog2(blocks);
    endfunction

    function automatic upd_e classify(input logic touched, input int held,
                                      input int add, input int sub,
                                      input int total);
        int sum;
        sum = held + add - sub;
        if (!touched)      return UPD_IDLE;
        else if (sum < 0)  return UPD_UNDER;
        else if (sum > total) return UPD_OVER;
        else               return UPD_OK;
    endfunction

endpackage

// File: rtl/tok_slot.sv
`timescale 1ns/1ps
module tok_slot
    import tok_pkg::*;
#(
    parameter int TOTAL = 4,
    parameter int CNT_W = 3,
    parameter bit HOME  = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_ctl_t        ctl,
    input  logic [CNT_W-1:0] arr_cnt,
    input  logic [CNT_W-1:0] snd_cnt,
    output logic [CNT_W-1:0] cnt_q,
    output logic             dv_q,
    output logic [CNT_W-1:0] sent,
    output logic             bad
);

    logic [CNT_W-1:0] add_c;
    logic [CNT_W-1:0] sub_c;
    logic [CNT_W-1:0] nxt_c;
    upd_e             st;
    logic             legal;
    int               sum_i;

    always_comb begin
        add_c = ctl.arr_hit ? arr_cnt : '0;
        if (!ctl.snd_hit)     sub_c = '0;
        else if (ctl.snd_all) sub_c = cnt_q;
        else                  sub_c = snd_cnt;
        sum_i = int'(cnt_q) + int'(add_c) - int'(sub_c);
        st    = classify(ctl.arr_hit | ctl.snd_hit, int'(cnt_q),
                         int'(add_c), int'(sub_c), TOTAL);
        legal = (st == UPD_OK) || (st == UPD_IDLE);
        nxt_c = CNT_W'(sum_i);
        sent  = legal ? sub_c : '0;
        bad   = !legal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= HOME ? CNT_W'(TOTAL) : '0;
            dv_q  <= HOME;
        end else if (legal) begin
            cnt_q <= nxt_c;
            dv_q  <= (dv_q & ~(ctl.snd_hit & ctl.snd_all)) | (ctl.arr_hit & ctl.arr_data);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= TOTAL); // R8

    AST_REFUSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        bad |=> ($stable(cnt_q) && $stable(dv_q))); // R8

    AST_EVICT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (ctl.snd_hit && ctl.snd_all && !ctl.arr_hit) |=> (cnt_q == '0 && !dv_q)); // R6

    AST_MERGE_SUM: assert property (@(posedge clk) disable iff (rst)
        (ctl.arr_hit && ctl.snd_hit && !ctl.snd_all && !bad)
        |=> (int'(cnt_q) == $past(int'(cnt_q)) + $past(int'(arr_cnt)) - $past(int'(snd_cnt)))); // R7

endmodule

// File: rtl/tok_perm.sv
`timescale 1ns/1ps
module tok_perm #(
    parameter int TOTAL = 4,
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] cnt,
    output logic             rd,
    output logic             wr
);

    always_comb begin
        rd = (cnt != '0);
        wr = (cnt == CNT_W'(TOTAL));
    end

endmodule

// File: rtl/tok_tracker.sv
`timescale 1ns/1ps
module tok_tracker
    import tok_pkg::*;
#(
    parameter int NUM_BLOCKS   = 4,
    parameter int TOTAL_TOKENS = 4,
    parameter bit HOME_NODE    = 1'b0,
    localparam int CNT_W = cnt_width(TOTAL_TOKENS),
    localparam int IDX_W = idx_width(NUM_BLOCKS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        arr_valid,
    input  logic [IDX_W-1:0]            arr_idx,
    input  logic [CNT_W-1:0]            arr_count,
    input  logic                        arr_data,
    input  logic                        snd_valid,
    input  logic [IDX_W-1:0]            snd_idx,
    input  logic [CNT_W-1:0]            snd_count,
    input  logic                        snd_all,
    output logic [NUM_BLOCKS-1:0]       rd_ok,
    output logic [NUM_BLOCKS-1:0]       wr_ok,
    output logic [NUM_BLOCKS-1:0]       data_valid,
    output logic [NUM_BLOCKS*CNT_W-1:0] tok_cnt,
    output logic [CNT_W-1:0]            sent_count,
    output logic                        tok_err
);

    logic [CNT_W-1:0]      cnt_v  [NUM_BLOCKS];
    logic [CNT_W-1:0]      sent_v [NUM_BLOCKS];
    logic [NUM_BLOCKS-1:0] bad_v;
    logic                  any_bad;
    logic                  err_q;
    int                    total_now;
    int                    arr_amt;

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
        slot_ctl_t ctl;

        always_comb begin
            ctl.arr_hit  = arr_valid && (arr_idx == IDX_W'(i));
            ctl.arr_data = arr_data;
            ctl.snd_hit  = snd_valid && (snd_idx == IDX_W'(i));
            ctl.snd_all  = snd_all;
        end

        tok_slot #(
            .TOTAL (TOTAL_TOKENS),
            .CNT_W (CNT_W),
            .HOME  (HOME_NODE)
        ) u_slot (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl),
            .arr_cnt (arr_count),
            .snd_cnt (snd_count),
            .cnt_q   (cnt_v[i]),
            .dv_q    (data_valid[i]),
            .sent    (sent_v[i]),
            .bad     (bad_v[i])
        );

        tok_perm #(
            .TOTAL (TOTAL_TOKENS),
            .CNT_W (CNT_W)
        ) u_perm (
            .cnt (cnt_v[i]),
            .rd  (rd_ok[i]),
            .wr  (wr_ok[i])
        );

        assign tok_cnt[i*CNT_W +: CNT_W] = cnt_v[i];

        AST_ZERO_NO_PERM: assert property (@(posedge clk) disable iff (rst)
            (cnt_v[i] == '0) |-> (!rd_ok[i] && !wr_ok[i])); // R9

        AST_WR_NEEDS_RD: assert property (@(posedge clk) disable iff (rst)
            wr_ok[i] |-> rd_ok[i]); // R3
    end

    always_comb begin
        sent_count = '0;
        total_now  = 0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            sent_count = sent_count | sent_v[i];
            total_now  = total_now + int'(cnt_v[i]);
        end
        any_bad = |bad_v;
        arr_amt = (arr_valid && (int'(arr_idx) < NUM_BLOCKS)) ? int'(arr_count) : 0;
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= any_bad;
    end

    assign tok_err = err_q;

    AST_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        !any_bad |=> (total_now == $past(total_now) + $past(arr_amt) - $past(int'(sent_count)))); // R7

    AST_ONE_SENDER: assert property (@(posedge clk) disable iff (rst)
        !snd_valid |-> (sent_count == '0)); // R5

endmodule

// File: tb/tok_tracker_test.sv
`timescale 1ns/1ps
module tok_tracker_test;

    localparam int NB = 4;
    localparam int TT = 4;
    localparam int CW = 3;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // ---------------- unit under test (cache node) ----------------
    logic          arr_valid, arr_data, snd_valid, snd_all;
    logic [IW-1:0] arr_idx, snd_idx;
    logic [CW-1:0] arr_count, snd_count;
    logic [NB-1:0] rd_o, wr_o, dv_o;
    logic [NB*CW-1:0] cnt_o;
    logic [CW-1:0] sent_o;
    logic          err_o;

    tok_tracker #(.NUM_BLOCKS(NB), .TOTAL_TOKENS(TT), .HOME_NODE(1'b0)) uut (
        .clk(clk), .rst(rst),
        .arr_valid(arr_valid), .arr_idx(arr_idx), .arr_count(arr_count), .arr_data(arr_data),
        .snd_valid(snd_valid), .snd_idx(snd_idx), .snd_count(snd_count), .snd_all(snd_all),
        .rd_ok(rd_o), .wr_ok(wr_o), .data_valid(dv_o), .tok_cnt(cnt_o),
        .sent_count(sent_o), .tok_err(err_o)
    );

    // ---------------- two-node system: home + cache with transit ----------------
    logic          sys_go, sys_dir, sys_all;
    logic [IW-1:0] sys_idx;
    logic [CW-1:0] sys_cnt;
    logic          h2c_v, c2h_v;
    logic [IW-1:0] h2c_idx, c2h_idx;
    logic [CW-1:0] h2c_cnt, c2h_cnt;
    logic [NB-1:0] h_rd, h_wr, h_dv, c_rd, c_wr, c_dv;
    logic [NB*CW-1:0] h_cnt, c_cnt;
    logic [CW-1:0] h_sent, c_sent;
    logic          h_err, c_err;

    tok_tracker #(.NUM_BLOCKS(NB), .TOTAL_TOKENS(TT), .HOME_NODE(1'b1)) trk_home (
        .clk(clk), .rst(rst),
        .arr_valid(c2h_v), .arr_idx(c2h_idx), .arr_count(c2h_cnt), .arr_data(1'b1),
        .snd_valid(sys_go && !sys_dir), .snd_idx(sys_idx), .snd_count(sys_cnt), .snd_all(sys_all),
        .rd_ok(h_rd), .wr_ok(h_wr), .data_valid(h_dv), .tok_cnt(h_cnt),
        .sent_count(h_sent), .tok_err(h_err)
    );

    tok_tracker #(.NUM_BLOCKS(NB), .TOTAL_TOKENS(TT), .HOME_NODE(1'b0)) trk_cache (
        .clk(clk), .rst(rst),
        .arr_valid(h2c_v), .arr_idx(h2c_idx), .arr_count(h2c_cnt), .arr_data(1'b1),
        .snd_valid(sys_go && sys_dir), .snd_idx(sys_idx), .snd_count(sys_cnt), .snd_all(sys_all),
        .rd_ok(c_rd), .wr_ok(c_wr), .data_valid(c_dv), .tok_cnt(c_cnt),
        .sent_count(c_sent), .tok_err(c_err)
    );

    always @(posedge clk) begin
        if (rst) begin
            h2c_v <= 1'b0; c2h_v <= 1'b0;
            h2c_idx <= '0; c2h_idx <= '0; h2c_cnt <= '0; c2h_cnt <= '0;
        end else begin
            h2c_v   <= (h_sent != '0);
            h2c_idx <= sys_idx;
            h2c_cnt <= h_sent;
            c2h_v   <= (c_sent != '0);
            c2h_idx <= sys_idx;
            c2h_cnt <= c_sent;
        end
    end

    // ---------------- helpers ----------------
    task automatic expect_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ucnt(input int b);
        return int'(cnt_o[b*CW +: CW]);
    endfunction

    task automatic idle_uut();
        arr_valid = 1'b0; arr_idx = '0; arr_count = '0; arr_data = 1'b0;
        snd_valid = 1'b0; snd_idx = '0; snd_count = '0; snd_all = 1'b0;
    endtask

    int  m_cnt [NB];
    bit  m_dv  [NB];

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        idle_uut();
        sys_go = 1'b0; sys_dir = 1'b0; sys_all = 1'b0; sys_idx = '0; sys_cnt = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state of a cache node and a home node
        for (int b = 0; b < NB; b++) begin
            expect_eq("R1", "cache count", ucnt(b), 0);
            expect_eq("R1", "cache data_valid", int'(dv_o[b]), 0);
            expect_eq("R2", "cache rd_ok at reset", int'(rd_o[b]), 0);
            expect_eq("R1", "home count", int'(h_cnt[b*CW +: CW]), TT);
            expect_eq("R1", "home data_valid", int'(h_dv[b]), 1);
            expect_eq("R3", "home wr_ok at reset", int'(h_wr[b]), 1);
            m_cnt[b] = 0;
            m_dv[b]  = 1'b0;
        end
        expect_eq("R1", "tok_err", int'(err_o), 0);

        // Exhaustive sweep: block x start count x received x sent
        for (int b = 0; b < NB; b++) begin
            for (int old = 0; old <= TT; old++) begin
                for (int a = 0; a <= TT; a++) begin
                    for (int s = 0; s <= TT; s++) begin
                        int    sum;
                        bit    legal;
                        bit    dflag;
                        int    exp_c;
                        bit    exp_dv;
                        string req;

                        // R6: eviction with a misleading snd_count
                        idle_uut();
                        snd_valid = 1'b1; snd_idx = IW'(b); snd_all = 1'b1; snd_count = CW'(TT);
                        #1;
                        expect_eq("R6", "evict sent_count", int'(sent_o), m_cnt[b]);
                        @(negedge clk);
                        idle_uut();
                        expect_eq("R6", "count after evict", ucnt(b), 0);
                        expect_eq("R6", "data_valid after evict", int'(dv_o[b]), 0);
                        expect_eq("R6", "tok_err after evict", int'(err_o), 0);
                        m_cnt[b] = 0;
                        m_dv[b]  = 1'b0;

                        if (old > 0) begin
                            arr_valid = 1'b1; arr_idx = IW'(b); arr_count = CW'(old); arr_data = 1'b1;
                            @(negedge clk);
                            idle_uut();
                            expect_eq("R4", "count after load", ucnt(b), old);
                            expect_eq("R4", "data_valid after data arrival", int'(dv_o[b]), 1);
                            m_cnt[b] = old;
                            m_dv[b]  = 1'b1;
                        end

                        // combined arrival and send on the same block
                        sum   = old + a - s;
                        legal = (sum >= 0) && (sum <= TT);
                        dflag = ((a + s) % 2) == 1;
                        if (!legal)      req = "R8";
                        else if (s == 0) req = "R4";
                        else if (a == 0) req = "R5";
                        else             req = "R7";

                        arr_valid = 1'b1; arr_idx = IW'(b); arr_count = CW'(a); arr_data = dflag;
                        snd_valid = 1'b1; snd_idx = IW'(b); snd_count = CW'(s); snd_all = 1'b0;
                        #1;
                        expect_eq(req, "sent_count", int'(sent_o), legal ? s : 0);
                        @(negedge clk);
                        idle_uut();

                        exp_c  = legal ? sum : old;
                        exp_dv = legal ? (m_dv[b] | dflag) : m_dv[b];
                        expect_eq(req, "count", ucnt(b), exp_c);
                        expect_eq(req, "data_valid", int'(dv_o[b]), int'(exp_dv));
                        expect_eq("R8", "tok_err", int'(err_o), legal ? 0 : 1);
                        if (exp_c == 0 && exp_dv)
                            expect_eq("R9", "rd_ok with data but no tokens", int'(rd_o[b]), 0);
                        else
                            expect_eq("R2", "rd_ok", int'(rd_o[b]), (exp_c >= 1) ? 1 : 0);
                        expect_eq("R3", "wr_ok", int'(wr_o[b]), (exp_c == TT) ? 1 : 0);
                        for (int o = 0; o < NB; o++) begin
                            if (o != b) expect_eq("R10", "other block count", ucnt(o), m_cnt[o]);
                        end
                        m_cnt[b] = exp_c;
                        m_dv[b]  = exp_dv;
                    end
                end
            end
        end

        // R11: home and cache trade tokens through a transit stage
        for (int k = 0; k < 240; k++) begin
            @(negedge clk);
            for (int b = 0; b < NB; b++) begin
                int tot;
                tot = int'(h_cnt[b*CW +: CW]) + int'(c_cnt[b*CW +: CW]);
                if (h2c_v && int'(h2c_idx) == b) tot = tot + int'(h2c_cnt);
                if (c2h_v && int'(c2h_idx) == b) tot = tot + int'(c2h_cnt);
                expect_eq("R11", "system token total", tot, TT);
            end
            sys_go  = 1'b1;
            sys_dir = ((k / 3) % 2) == 1;
            sys_idx = IW'(k % NB);
            sys_cnt = CW'((k * 3) % (TT + 1));
            sys_all = (k % 5) == 4;
        end
        sys_go = 1'b0;
        repeat (2) @(negedge clk);
        for (int b = 0; b < NB; b++) begin
            expect_eq("R11", "drained total",
                      int'(h_cnt[b*CW +: CW]) + int'(c_cnt[b*CW +: CW]), TT);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule